// File: doc/BRIEF.md
# DDR Interleaved Converter Sample Capture

This block rebuilds full-width converter samples that arrive over a data bus half as wide as the sample. The converter sends each sample as two halves on consecutive system clock cycles. The first half holds the even-indexed sample bits and the second half holds the odd-indexed bits. The whole block runs in one system clock domain, nominally 100 MHz. It also produces the converter's sample clock: a register toggles every system cycle, which gives half the system rate, and one more register stage sits between that toggle and the output pin.

The data lines and the converter's data-clock-out line first pass together through one input register stage. A capture stage follows. Each half is loaded into its own full-width register with every bit already at its final position, and the unused positions are written to zero. The two registers are then ORed into the sample. No multiplexer is used. A parameter picks which level of the sample clock marks the even half, so the phase can be matched to the converter and board delay. The assembled sample is registered and announced with a one-cycle valid pulse once per sample clock period.

Top module: `ddr_adc_capture`

## Requirements
- R1: `convClk` is 0 while reset is applied. It toggles on every system clock edge from the second cycle after reset is released, so its rate is half the system clock.
- R2: `dcoQ` equals the value that `convDco` had at the previous clock edge.
- R3: With `PHASE_SEL` = 0, a bus value sampled at an edge is the even half when `convClk` was 1 during the cycle ending at that edge, and the odd half when `convClk` was 0.
- R4: Bus bit i of the even half appears at sample bit 2i. Bus bit i of the odd half appears at sample bit 2i+1.
- R5: `sampleValid` is a single-cycle pulse. Once samples are flowing it repeats exactly every 2 cycles.
- R6: `sample` changes only in cycles where `sampleValid` is high, and holds its value in between.
- R7: If the odd half of a sample is sampled at clock edge k, then `sample` and `sampleValid` present that sample in the cycle after edge k+2.
- R8: A synchronous active-high reset clears `sample`, `sampleValid` and `convClk`. After reset, no pulse is raised until an even half and then an odd half have both been captured.
- R9: With `PHASE_SEL` = 1, the even/odd rule of R3 is inverted: a bus value is the even half when `convClk` was 0 in the cycle ending at the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| convData | input | BUS_W | Half-sample data bus from the converter |
| convDco | input | 1 | Data-clock-out line from the converter |
| convClk | output | 1 | Registered sample clock to the converter |
| dcoQ | output | 1 | Data-clock-out after the input register stage |
| sample | output | 2*BUS_W | Reassembled sample, held between pulses |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bench builds two copies at the default 8-bit bus width. One has `PHASE_SEL` = 0 and the other has `PHASE_SEL` = 1, so both even/odd phase assignments run side by side against the same sample list. Each copy is fed by its own converter model, which picks the half to drive from the sample clock that the copy itself produces. Any mismatch in the phase rule or in the bit interleave therefore shows up as a wrong word. A reset in the middle of the stream shows that no partial sample leaks out, and that the first pulse after reset carries the first fully sent sample.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;
  // Strobes passed from the phase control to the datapath
  typedef struct packed {
    logic loadEven;   // capture register for even bits loads this cycle
    logic loadOdd;    // capture register for odd bits loads this cycle
    logic publish;    // register the merged word and raise the pulse
  } capStrobes_t;
endpackage

// File: rtl/ddrcap_ctrl.sv
module ddrcap_ctrl
  import ddrcap_pkg::*;
#(
  parameter bit PHASE_SEL = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  output logic        convClkOut,
  output capStrobes_t stb
);
  logic clkToggle;
  logic clkPipe;
  logic phaseReg;
  logic evenSeen;
  logic publishReg;
  logic evenNow;

  // phaseReg holds the pin level during the cycle in which the data
  // now sitting in the input register was sampled.
  always_comb begin
    evenNow      = phaseReg ^ PHASE_SEL;
    stb.loadEven = evenNow;
    stb.loadOdd  = ~evenNow;
    stb.publish  = publishReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkToggle  <= 1'b0;
      clkPipe    <= 1'b0;
      phaseReg   <= 1'b0;
      evenSeen   <= 1'b0;
      publishReg <= 1'b0;
    end else begin
      clkToggle  <= ~clkToggle;
      clkPipe    <= clkToggle;
      phaseReg   <= clkPipe;
      if (evenNow) begin
        evenSeen <= 1'b1;
      end
      publishReg <= ~evenNow & evenSeen;
    end
  end

  assign convClkOut = clkPipe;
endmodule

// File: rtl/ddrcap_dpath.sv
module ddrcap_dpath
  import ddrcap_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BUS_W-1:0]     busIn,
  input  logic                 dcoIn,
  input  capStrobes_t          stb,
  output logic [2*BUS_W-1:0]   sampleOut,
  output logic                 validOut,
  output logic                 dcoOut
);
  localparam int SAMPLE_W = 2 * BUS_W;
  localparam int PIPE_W   = BUS_W + 1;

  logic [PIPE_W-1:0]   inPipe;
  logic [SAMPLE_W-1:0] evenSpread;
  logic [SAMPLE_W-1:0] oddSpread;
  logic [SAMPLE_W-1:0] evenReg;
  logic [SAMPLE_W-1:0] oddReg;
  logic [SAMPLE_W-1:0] merged;

  // Spread the registered bus onto interleaved positions
  for (genvar i = 0; i < BUS_W; i++) begin : gSpread
    assign evenSpread[2*i]   = inPipe[i];
    assign evenSpread[2*i+1] = 1'b0;
    assign oddSpread[2*i]    = 1'b0;
    assign oddSpread[2*i+1]  = inPipe[i];
  end

  assign merged = evenReg | oddReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      inPipe    <= '0;
      evenReg   <= '0;
      oddReg    <= '0;
      sampleOut <= '0;
      validOut  <= 1'b0;
    end else begin
      inPipe   <= {dcoIn, busIn};
      if (stb.loadEven) begin
        evenReg <= evenSpread;
      end
      if (stb.loadOdd) begin
        oddReg <= oddSpread;
      end
      validOut <= stb.publish;
      if (stb.publish) begin
        sampleOut <= merged;
      end
    end
  end

  assign dcoOut = inPipe[PIPE_W-1];
endmodule

// File: rtl/ddr_adc_capture.sv
module ddr_adc_capture
  import ddrcap_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter bit PHASE_SEL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BUS_W-1:0]     convData,
  input  logic                 convDco,
  output logic                 convClk,
  output logic                 dcoQ,
  output logic [2*BUS_W-1:0]   sample,
  output logic                 sampleValid
);
  capStrobes_t stb;

  ddrcap_ctrl #(.PHASE_SEL(PHASE_SEL)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .convClkOut (convClk),
    .stb        (stb)
  );

  ddrcap_dpath #(.BUS_W(BUS_W)) uDpath (
    .clk       (clk),
    .rst       (rst),
    .busIn     (convData),
    .dcoIn     (convDco),
    .stb       (stb),
    .sampleOut (sample),
    .validOut  (sampleValid),
    .dcoOut    (dcoQ)
  );
endmodule

// File: rtl/ddrcap_checker.sv
module ddrcap_checker #(
  parameter int BUS_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               convDco,
  input logic               convClk,
  input logic               dcoQ,
  input logic [2*BUS_W-1:0] sample,
  input logic               sampleValid
);
  logic [1:0] postRst;

  always_ff @(posedge clk) begin
    if (rst) postRst <= 2'd0;
    else if (postRst != 2'd3) postRst <= postRst + 2'd1;
  end

  // R1: the sample clock flips on every edge once the pipe has filled
  a_r1_clk_toggles: assert property (@(posedge clk) disable iff (rst)
    (postRst >= 2'd2) |-> (convClk != $past(convClk)));

  // R2: data-clock-out is delayed by exactly one register stage
  a_r2_dco_pipe: assert property (@(posedge clk) disable iff (rst)
    (postRst >= 2'd1) |-> (dcoQ == $past(convDco)));

  // R5: the pulse lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  // R5: once started, pulses repeat every second cycle
  a_r5_period: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> ##2 sampleValid);

  // R6: the word holds between pulses
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (postRst >= 2'd1 && !sampleValid) |-> $stable(sample));

  // R8: reset clears outputs on the next edge
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!sampleValid && sample == '0 && !convClk));
endmodule

bind ddr_adc_capture ddrcap_checker #(.BUS_W(BUS_W)) uChk (
  .clk         (clk),
  .rst         (rst),
  .convDco     (convDco),
  .convClk     (convClk),
  .dcoQ        (dcoQ),
  .sample      (sample),
  .sampleValid (sampleValid)
);

// File: tb/sim_ddr_adc_capture.sv
module sim_ddr_adc_capture;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W      = 8;
  localparam int SW         = 2 * BUS_W;
  localparam int NSMP       = 48;
  localparam int MID_RST    = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BUS_W-1:0] bus [2];
  logic dco [2];
  logic ck [2];
  logic dq [2];
  logic [SW-1:0] smp [2];
  logic vld [2];

  logic [SW-1:0] smpMem [NSMP];
  int idx [2];
  bit evenDriven [2];
  int oddCyc [2][NSMP];
  int rcv [2];
  int lastValid [2];
  logic [SW-1:0] held [2];
  logic dcoPrev [2];
  logic ckPrev [2];
  int cyc = 0;
  int postCnt = 0;
  int rstCnt = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  ddr_adc_capture #(.BUS_W(BUS_W), .PHASE_SEL(1'b0)) u0 (
    .clk(clk), .rst(rst), .convData(bus[0]), .convDco(dco[0]),
    .convClk(ck[0]), .dcoQ(dq[0]), .sample(smp[0]), .sampleValid(vld[0]));

  ddr_adc_capture #(.BUS_W(BUS_W), .PHASE_SEL(1'b1)) u1 (
    .clk(clk), .rst(rst), .convData(bus[1]), .convDco(dco[1]),
    .convClk(ck[1]), .dcoQ(dq[1]), .sample(smp[1]), .sampleValid(vld[1]));

  function automatic logic [BUS_W-1:0] evenHalf(logic [SW-1:0] s);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < BUS_W; i++) r[i] = s[2*i];
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] oddHalf(logic [SW-1:0] s);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < BUS_W; i++) r[i] = s[2*i+1];
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor and converter model, both on the falling edge
  always @(negedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (rst) begin
        if (rstCnt >= 2) begin
          chk(!vld[m] && smp[m] == '0 && !ck[m], "R8 reset state",
              {vld[m], ck[m], smp[m]}, 0);
        end
      end else if (running) begin
        if (postCnt >= 1) chk(dq[m] == dcoPrev[m], "R2 dco pipe", dq[m], dcoPrev[m]);
        if (postCnt >= 3) chk(ck[m] != ckPrev[m], "R1 clock toggles", ck[m], ~ckPrev[m]);
        if (vld[m]) begin
          if (lastValid[m] >= 0) chk(cyc - lastValid[m] == 2, "R5 pulse spacing",
                                     cyc - lastValid[m], 2);
          lastValid[m] = cyc;
          if (rcv[m] < idx[m]) begin
            if (m == 0) chk(smp[m] == smpMem[rcv[m]], "R4 R3 word phase0",
                            smp[m], smpMem[rcv[m]]);
            else        chk(smp[m] == smpMem[rcv[m]], "R9 R4 word phase1",
                            smp[m], smpMem[rcv[m]]);
            chk(cyc == oddCyc[m][rcv[m]] + 2, "R7 latency", cyc, oddCyc[m][rcv[m]] + 2);
            rcv[m]++;
          end else if (idx[m] < NSMP) begin
            chk(1'b0, "R8 early pulse", smp[m], 0);
          end
          held[m] = smp[m];
        end else begin
          chk(smp[m] == held[m], "R6 hold", smp[m], held[m]);
        end
      end
      ckPrev[m] = ck[m];
      // converter model
      if (rst || !running) begin
        bus[m] = '0;
        evenDriven[m] = 1'b0;
        dco[m] = 1'b0;
      end else begin
        dco[m] = 1'($urandom());
        if ((ck[m] ^ (m == 1)) == 1'b1) begin
          if (idx[m] < NSMP) begin
            bus[m] = evenHalf(smpMem[idx[m]]);
            evenDriven[m] = 1'b1;
          end else begin
            bus[m] = '0;
          end
        end else begin
          bus[m] = (idx[m] < NSMP) ? oddHalf(smpMem[idx[m]]) : '0;
          if (evenDriven[m]) begin
            oddCyc[m][idx[m]] = cyc + 1;
            idx[m]++;
            evenDriven[m] = 1'b0;
          end
        end
      end
      dcoPrev[m] = dco[m];
    end
    if (rst) rstCnt++;
    else begin
      rstCnt = 0;
      if (running) postCnt++;
    end
  end

  task automatic releaseReset();
    for (int m = 0; m < 2; m++) begin
      rcv[m] = idx[m];
      lastValid[m] = -1;
      held[m] = '0;
    end
    postCnt = 0;
    @(posedge clk);
    #1 rst = 1'b0;
    running = 1'b1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NSMP; i++) smpMem[i] = SW'($urandom());
    smpMem[0] = 16'hFFFF; smpMem[1] = 16'h5555; smpMem[2] = 16'hAAAA;
    smpMem[3] = 16'h0001; smpMem[4] = 16'h8000; smpMem[5] = 16'h0000;
    smpMem[6] = 16'h00FF; smpMem[7] = 16'hFF00;
    smpMem[MID_RST] = 16'hFFFF; smpMem[MID_RST+1] = 16'hAAAA;
    for (int m = 0; m < 2; m++) begin
      idx[m] = 0; rcv[m] = 0; lastValid[m] = -1; held[m] = '0;
      bus[m] = '0; dco[m] = 1'b0; dcoPrev[m] = 1'b0; ckPrev[m] = 1'b0;
    end
    rst = 1'b1;
    repeat (5) @(posedge clk);
    releaseReset();
    wait (idx[0] >= MID_RST && idx[1] >= MID_RST);
    @(posedge clk);
    #1 rst = 1'b1;           // R8: reset in the middle of the stream
    running = 1'b0;
    repeat (4) @(posedge clk);
    releaseReset();
    wait (idx[0] >= NSMP && idx[1] >= NSMP);
    repeat (8) @(posedge clk);
    chk(rcv[0] == NSMP, "R5 all words seen phase0", rcv[0], NSMP);
    chk(rcv[1] == NSMP, "R9 all words seen phase1", rcv[1], NSMP);
    done = 1'b1;
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finishRun();
    end
  end
endmodule